// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

The controller takes one level-sensitive interrupt request line from each device and arbitrates among them with a fixed priority that depends only on the channel number. Channel 0 is the most urgent. Channel N-1 is the least urgent. It presents a single interrupt line and a binary channel vector to the processor. When the processor acknowledges, which it does after finishing its current instruction and saving its state, the controller records the chosen channel as in service and raises that device's own grant line.

In-service levels are kept on an internal stack whose depth equals the channel count, so every level can nest once. While a channel is in service, only a strictly more urgent request raises the interrupt line again. Requests of equal or lower urgency wait until the service ends. An end-of-service strobe pops the stack, the previous level becomes current again, and arbitration resumes against it. An end-of-service strobe with nothing in service changes nothing and sets a sticky error flag.

Top module: `nest_irq_ctrl`

## Requirements
- R1: Each channel has its own request input and its own grant output. At most one grant bit is high at any time, and it belongs to the channel at the top of the service stack.
- R2: Priority is fixed by channel index, and a lower index is more urgent. With nothing in service, any single active request raises irq_o with vec_o equal to its index.
- R3: When several eligible requests are active together, vec_o is the lowest eligible index, and irq_o and vec_o follow req_i in the same cycle.
- R4: While a channel is in service, requests at the same or a higher index keep irq_o low.
- R5: A request at a lower index than the channel in service raises irq_o at once, with vec_o equal to that index.
- R6: An ack_i sampled while irq_o is high pushes vec_o. After that clock edge, grant_o is the one-hot of that channel. An ack_i sampled while irq_o is low leaves grant_o unchanged.
- R7: An eoi_i sampled with a non-empty stack pops it. After that edge, grant_o returns to the previously served channel, or to zero if none remains, and irq_o is re-evaluated against that level.
- R8: The stack holds N_CH entries, so all channels can nest, one inside the next, and then unwind in order.
- R9: An eoi_i sampled with an empty stack leaves grant_o at zero and sets err_o. err_o stays high until reset.
- R10: If ack_i and eoi_i are sampled in the same cycle, the end-of-service wins and the acknowledge is ignored.
- R11: After reset, grant_o is zero, err_o is low, and the stack is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | N_CH | Level request, one bit per channel |
| ack_i | input | 1 | Processor acknowledge (state saved, vector taken) |
| eoi_i | input | 1 | End of service of the current level |
| grant_o | output | N_CH | One-hot grant to the channel in service |
| irq_o | output | 1 | Interrupt to the processor |
| vec_o | output | $clog2(N_CH) | Index of the channel offered, valid with irq_o |
| err_o | output | 1 | Sticky flag for an end-of-service with empty stack |

## Verification
A corrupted stack entry or count shows on grant_o in the cycle right after the end-of-service edge that exposes it: either the wrong bit comes back or the grant drops to zero. A wrong service ceiling shows in the same cycle on irq_o and vec_o. Either a lower request gets through, or a more urgent one is held back. The directed tests therefore nest several levels, unwind them one pop at a time and check grant_o after each edge. They check irq_o and vec_o combinationally after each change of req_i.

// File: rtl/nic_pkg.sv
package nic_pkg;
   typedef enum logic [1:0] {
      STK_HOLD = 2'd0,
      STK_PUSH = 2'd1,
      STK_POP  = 2'd2
   } stk_op_e;
endpackage

// File: rtl/nic_prio_sel.sv
module nic_prio_sel #(
   parameter int N_CH  = 8,
   parameter int IDX_W = 3,
   parameter int LVL_W = 4
) (
   input  logic [N_CH-1:0]  req_i,
   input  logic [LVL_W-1:0] ceil_i,
   output logic             hit_o,
   output logic [IDX_W-1:0] idx_o
);
   logic [N_CH-1:0] elig;

   // only channels strictly more urgent than the ceiling are eligible
   for (genvar g = 0; g < N_CH; g++) begin : g_mask
      assign elig[g] = req_i[g] && (LVL_W'(g) < ceil_i);
   end

   always_comb begin
      hit_o = 1'b0;
      idx_o = '0;
      for (int i = N_CH - 1; i >= 0; i--) begin
         if (elig[i]) begin
            hit_o = 1'b1;
            idx_o = IDX_W'(i);
         end
      end
   end
endmodule

// File: rtl/nic_svc_stack.sv
module nic_svc_stack
   import nic_pkg::*;
#(
   parameter int N_CH  = 8,
   parameter int IDX_W = 3,
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  stk_op_e          op_i,
   input  logic [IDX_W-1:0] push_idx_i,
   output logic [IDX_W-1:0] top_o,
   output logic             empty_o,
   output logic [CNT_W-1:0] cnt_o
);
   logic [IDX_W-1:0] slot_q [N_CH];
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
         for (int i = 0; i < N_CH; i++) slot_q[i] <= '0;
      end else begin
         unique case (op_i)
            STK_PUSH: begin
               if (cnt_q < CNT_W'(N_CH)) begin
                  for (int i = 0; i < N_CH; i++)
                     if (cnt_q == CNT_W'(i)) slot_q[i] <= push_idx_i;
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            STK_POP: if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
            default: ;
         endcase
      end
   end

   always_comb begin
      top_o = '0;
      for (int i = 0; i < N_CH; i++)
         if (cnt_q == CNT_W'(i + 1)) top_o = slot_q[i];
   end

   assign empty_o = (cnt_q == '0);
   assign cnt_o   = cnt_q;
endmodule

// File: rtl/nest_irq_ctrl.sv
module nest_irq_ctrl
   import nic_pkg::*;
#(
   parameter int N_CH = 8
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [N_CH-1:0]         req_i,
   input  logic                    ack_i,
   input  logic                    eoi_i,
   output logic [N_CH-1:0]         grant_o,
   output logic                    irq_o,
   output logic [$clog2(N_CH)-1:0] vec_o,
   output logic                    err_o
);
   localparam int IDX_W = $clog2(N_CH);
   localparam int LVL_W = $clog2(N_CH + 1);
   localparam int CNT_W = LVL_W;

   if (N_CH < 2 || N_CH > 64) begin : g_bad_n
      $error("nest_irq_ctrl: N_CH must lie in 2..64");
   end

   stk_op_e          stk_op;
   logic [IDX_W-1:0] top_idx;
   logic             stk_empty;
   logic [CNT_W-1:0] svc_depth;
   logic [LVL_W-1:0] ceil;
   logic             hit;
   logic [IDX_W-1:0] pick;
   logic             err_q;

   assign ceil = stk_empty ? LVL_W'(N_CH) : LVL_W'(top_idx);

   nic_prio_sel #(.N_CH(N_CH), .IDX_W(IDX_W), .LVL_W(LVL_W)) u_sel (
      .req_i (req_i),
      .ceil_i(ceil),
      .hit_o (hit),
      .idx_o (pick)
   );

   // end-of-service has precedence over a simultaneous acknowledge
   always_comb begin
      if (eoi_i && !stk_empty)    stk_op = STK_POP;
      else if (ack_i && hit && !eoi_i) stk_op = STK_PUSH;
      else                        stk_op = STK_HOLD;
   end

   nic_svc_stack #(.N_CH(N_CH), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_stk (
      .clk       (clk),
      .rst_n     (rst_n),
      .op_i      (stk_op),
      .push_idx_i(pick),
      .top_o     (top_idx),
      .empty_o   (stk_empty),
      .cnt_o     (svc_depth)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)                     err_q <= 1'b0;
      else if (eoi_i && stk_empty)    err_q <= 1'b1;
   end

   for (genvar g = 0; g < N_CH; g++) begin : g_grant
      assign grant_o[g] = !stk_empty && (top_idx == IDX_W'(g));
   end

   assign irq_o = hit;
   assign vec_o = pick;
   assign err_o = err_q;
endmodule

// File: rtl/nest_irq_chk.sv
module nest_irq_chk #(
   parameter int N_CH  = 8,
   parameter int IDX_W = 3,
   parameter int CNT_W = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic [N_CH-1:0]  req_i,
   input logic             ack_i,
   input logic             eoi_i,
   input logic [N_CH-1:0]  grant_o,
   input logic             irq_o,
   input logic [IDX_W-1:0] vec_o,
   input logic             err_o,
   input logic [CNT_W-1:0] depth
);
   logic [N_CH-1:0] upto_vec;
   always_comb
      for (int i = 0; i < N_CH; i++) upto_vec[i] = (IDX_W'(i) <= vec_o);

   p_grant_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant_o));

   p_vec_requested_r3: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> req_i[vec_o]);

   p_preempt_higher_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_o && grant_o != '0) |-> ((grant_o & upto_vec) == '0));

   p_ack_grant_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_i && irq_o && !eoi_i) |=> grant_o[$past(vec_o)]);

   p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
      depth <= CNT_W'(N_CH));

   p_eoi_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (eoi_i && grant_o == '0) |=> err_o);

   p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      err_o |=> err_o);
endmodule

bind nest_irq_ctrl nest_irq_chk #(.N_CH(N_CH), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .req_i  (req_i),
   .ack_i  (ack_i),
   .eoi_i  (eoi_i),
   .grant_o(grant_o),
   .irq_o  (irq_o),
   .vec_o  (vec_o),
   .err_o  (err_o),
   .depth  (svc_depth)
);

// File: tb/sim_nest_irq_ctrl.sv
module sim_nest_irq_ctrl;
   localparam int CLK_PERIOD = 10;
   localparam int N = 8;
   localparam int IW = $clog2(N);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [N-1:0] req = '0;
   logic ack = 1'b0, eoi = 1'b0;
   logic [N-1:0] grant;
   logic irq, err;
   logic [IW-1:0] vec;
   int n_chk = 0, n_bad = 0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   nest_irq_ctrl #(.N_CH(N)) u0 (
      .clk(clk), .rst_n(rst_n), .req_i(req), .ack_i(ack), .eoi_i(eoi),
      .grant_o(grant), .irq_o(irq), .vec_o(vec), .err_o(err)
   );

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic edge1();
      @(posedge clk); #1;
   endtask

   task automatic do_reset();
      req = '0; ack = 0; eoi = 0; rst_n = 0;
      edge1(); edge1();
      rst_n = 1; #1;
   endtask

   task automatic set_req(input logic [N-1:0] r);
      req = r; #1;
   endtask

   task automatic pulse_ack();
      ack = 1; edge1(); ack = 0; #1;
   endtask

   task automatic pulse_eoi();
      eoi = 1; edge1(); eoi = 0; #1;
   endtask

   task automatic t_reset();
      do_reset();
      chk("R11 grant", int'(grant), 0);
      chk("R11 err", int'(err), 0);
      chk("R11 irq", int'(irq), 0);
   endtask

   task automatic t_arbitrate();
      do_reset();
      set_req(8'b0100_0000);
      chk("R2 irq single", int'(irq), 1);
      chk("R2 vec single", int'(vec), 6);
      set_req(8'b0110_0100);
      chk("R3 vec of three", int'(vec), 2);
      set_req(8'b1000_0001);
      chk("R3 vec ch0 wins", int'(vec), 0);
      chk("R1 no grant before ack", int'(grant), 0);
   endtask

   task automatic t_nest();
      do_reset();
      set_req(8'b0001_0000);
      pulse_ack();
      chk("R6 grant ch4", int'(grant), 8'h10);
      chk("R4 equal held", int'(irq), 0);
      set_req(8'b0101_0000);
      chk("R4 lower held", int'(irq), 0);
      set_req(8'b0101_0010);
      chk("R5 irq higher", int'(irq), 1);
      chk("R5 vec higher", int'(vec), 1);
      pulse_ack();
      chk("R6 grant ch1", int'(grant), 8'h02);
      set_req(8'b0101_0000);
      pulse_eoi();
      chk("R7 back to ch4", int'(grant), 8'h10);
      set_req(8'b0100_0000);
      pulse_eoi();
      chk("R7 stack empty grant", int'(grant), 0);
      chk("R7 ch6 rearbitrated irq", int'(irq), 1);
      chk("R7 ch6 vec", int'(vec), 6);
      chk("R7 no err", int'(err), 0);
   endtask

   task automatic t_ack_idle();
      do_reset();
      pulse_ack();
      chk("R6 ack idle ignored", int'(grant), 0);
      set_req(8'b0000_1000);
      chk("R6 grant waits ack", int'(grant), 0);
      pulse_ack();
      chk("R6 grant ch3", int'(grant), 8'h08);
   endtask

   task automatic t_err();
      do_reset();
      pulse_eoi();
      chk("R9 err set", int'(err), 1);
      chk("R9 grant zero", int'(grant), 0);
      edge1(); edge1();
      chk("R9 err sticky", int'(err), 1);
      set_req(8'b0010_0000);
      pulse_ack();
      chk("R9 stack intact after bad eoi", int'(grant), 8'h20);
      do_reset();
      chk("R11 err cleared", int'(err), 0);
   endtask

   task automatic t_full_depth();
      logic [N-1:0] r;
      do_reset();
      r = '0;
      for (int ch = N - 1; ch >= 0; ch--) begin
         r[ch] = 1'b1;
         set_req(r);
         chk("R8 vec on nest", int'(vec), ch);
         pulse_ack();
         chk("R8 grant on nest", int'(grant), 1 << ch);
      end
      chk("R8 irq quiet when full", int'(irq), 0);
      for (int ch = 0; ch < N; ch++) begin
         r[ch] = 1'b0;
         set_req(r);
         pulse_eoi();
         chk("R8 grant on unwind", int'(grant), (ch < N - 1) ? (1 << (ch + 1)) : 0);
      end
      chk("R8 no err after unwind", int'(err), 0);
   endtask

   task automatic t_ack_eoi_same();
      do_reset();
      set_req(8'b0001_0000);
      pulse_ack();
      set_req(8'b0000_0100);
      chk("R10 irq ch2", int'(irq), 1);
      ack = 1; eoi = 1; edge1(); ack = 0; eoi = 0; #1;
      chk("R10 grant zero", int'(grant), 0);
      chk("R10 irq still up", int'(irq), 1);
      chk("R10 vec ch2", int'(vec), 2);
      chk("R10 no err", int'(err), 0);
   endtask

   task automatic finish_run();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      #3;
      t_reset();
      t_arbitrate();
      t_nest();
      t_ack_idle();
      t_err();
      t_full_depth();
      t_ack_eoi_same();
      finish_run();
   end
endmodule